// File: doc/BRIEF.md
# Sticky Status and Dual Interrupt Unit

This block keeps the status word of a storage-card host controller. Eleven event strobes from the command and data engines set sticky bits. The bits stay set until software writes ones to a clear register. Eleven FIFO flag bits from the data path are not stored: they pass straight through into the upper part of the same status word.

Two mask registers select which status bits raise each of two level interrupt lines. The block also has these parts:
- a set of 8-bit control registers (power, clock, data control);
- a readback of the remaining transfer length in whole 32-bit words;
- a read-only identification area of eight bytes, one byte per word.

When the status word or the word count is read while the data engine is held off, the block pulses a release output. The value returned is always the one from before the read.

Access is through a simple register port with a 12-bit byte address. Reads return their data one clock after the read strobe.

Top module: `status_irq_unit`

## Requirements
- R1: A high bit on `evt_set[k]` at a rising clock edge sets status bit k. The bit stays set until a clear write removes it.
- R2: A write to offset 0x38 clears status bit k for each k in [10:0] where the written data bit k is 1. Written bits 31:11 have no effect.
- R3: If an event strobe and a clear write hit the same bit at the same edge, the bit ends up set.
- R4: A read of offset 0x34 returns the status word: sticky bits at [10:0], the live `fifo_live[10:0]` inputs at [21:11], and zeros at [31:22].
- R5: Two 32-bit mask registers, read/write at 0x3C (mask 0) and 0x40 (mask 1). `irq[i]` is high whenever the bitwise AND of the current status word and mask i is nonzero.
- R6: A read of offset 0x48 returns (`bytes_left` + 3) / 4, rounded down, with no overflow at the largest count.
- R7: Reads in 0xFE0 to 0xFFF return one identification byte per word. The bytes are selected by address bits [4:2] and are, in order, 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in bits [7:0] with zeros above.
- R8: The registers at 0x00 (power), 0x04 (clock) and 0x2C (data control) store only the low 8 bits of a write and read back with zeros above.
- R9: A read of 0x34 or 0x48 while `hold_pending` is high pulses `xfer_release` high for one cycle, in the same cycle as the read data. A read of any other offset never pulses it.
- R10: A read of an unmapped or write-only offset (including 0x38) returns zero. A write to an unmapped or read-only offset changes no register.
- R11: `reg_rdata` is registered. It carries the read value in the cycle after `reg_rd` and zero in every other cycle. After reset, all registers, `reg_rdata`, `irq` and `xfer_release` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| evt_set | input | 11 | Sticky event strobes, one per status bit |
| fifo_live | input | 11 | Live FIFO flags shown at status bits [21:11] |
| bytes_left | input | 16 | Remaining transfer length in bytes |
| hold_pending | input | 1 | The data engine is currently held off |
| irq | output | 2 | Level interrupt outputs, one per mask |
| xfer_release | output | 1 | One-cycle pulse that releases the held-off engine |

## Verification
Read data and the release pulse are due exactly one edge after the read strobe. A sticky bit, and any interrupt it causes, appears one edge after its strobe or clear write. A live FIFO flag reaches the interrupt lines in the same cycle, with no register in the path.

The bench drives inputs at the falling edge and advances its reference model at the rising edge. It compares every output at the next falling edge, so each result is checked in the cycle it is due. Same-edge set and clear, the largest byte count, and every identification byte are covered as separate patterns.

// File: rtl/sst_pkg.sv
package sst_pkg;
   // Byte offsets; neighbouring software decodes these
   localparam int OFF_POWER  = 'h000;
   localparam int OFF_CLOCK  = 'h004;
   localparam int OFF_DCTRL  = 'h02C;
   localparam int OFF_STATUS = 'h034;
   localparam int OFF_CLEAR  = 'h038;
   localparam int OFF_MASK0  = 'h03C;
   localparam int OFF_FCOUNT = 'h048;
   localparam int ID_BASE    = 'hFE0;

   // Identification byte by word index inside the ID window
   function automatic logic [7:0] id_byte(input logic [2:0] idx);
      case (idx)
         3'd0:    id_byte = 8'h81;
         3'd1:    id_byte = 8'h11;
         3'd2:    id_byte = 8'h04;
         3'd3:    id_byte = 8'h00;
         3'd4:    id_byte = 8'h0D;
         3'd5:    id_byte = 8'hF0;
         3'd6:    id_byte = 8'h05;
         default: id_byte = 8'hB1;
      endcase
   endfunction
endpackage

// File: rtl/sst_sticky.sv
module sst_sticky #(
   parameter int EVT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] set_i,
   input  logic [EVT_W-1:0] clr_i,
   output logic [EVT_W-1:0] sticky_q
);
   // Set wins over clear on the same bit
   always_ff @(posedge clk) begin
      if (!rst_n) sticky_q <= '0;
      else        sticky_q <= (sticky_q & ~clr_i) | set_i;
   end
endmodule

// File: rtl/sst_ctlregs.sv
module sst_ctlregs #(
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 32,
   parameter int NUM_IRQ = 2,
   parameter int NARROW_W = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [DATA_W-1:0]               wdata,
   output logic [NARROW_W-1:0]             power_q,
   output logic [NARROW_W-1:0]             clock_q,
   output logic [NARROW_W-1:0]             dctrl_q,
   output logic [NUM_IRQ-1:0][DATA_W-1:0]  mask_q
);
   import sst_pkg::*;

   logic hit_pow, hit_clk, hit_dct;
   assign hit_pow = wr_en && (addr == ADDR_W'(OFF_POWER));
   assign hit_clk = wr_en && (addr == ADDR_W'(OFF_CLOCK));
   assign hit_dct = wr_en && (addr == ADDR_W'(OFF_DCTRL));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         power_q <= '0;
         clock_q <= '0;
         dctrl_q <= '0;
      end else begin
         if (hit_pow) power_q <= wdata[NARROW_W-1:0];
         if (hit_clk) clock_q <= wdata[NARROW_W-1:0];
         if (hit_dct) dctrl_q <= wdata[NARROW_W-1:0];
      end
   end

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_mask
      logic hit_m;
      assign hit_m = wr_en && (addr == ADDR_W'(OFF_MASK0 + 4 * i));
      always_ff @(posedge clk) begin
         if (!rst_n)     mask_q[i] <= '0;
         else if (hit_m) mask_q[i] <= wdata;
      end
   end
endmodule

// File: rtl/sst_irq.sv
module sst_irq #(
   parameter int DATA_W  = 32,
   parameter int NUM_IRQ = 2
) (
   input  logic [DATA_W-1:0]              status_w,
   input  logic [NUM_IRQ-1:0][DATA_W-1:0] mask_q,
   output logic [NUM_IRQ-1:0]             irq
);
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      assign irq[i] = |(status_w & mask_q[i]);
   end
endmodule

// File: rtl/status_irq_unit.sv
module status_irq_unit #(
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 32,
   parameter int EVT_W   = 11,
   parameter int LIVE_W  = 11,
   parameter int CNT_W   = 16,
   parameter int NUM_IRQ = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [EVT_W-1:0]   evt_set,
   input  logic [LIVE_W-1:0]  fifo_live,
   input  logic [CNT_W-1:0]   bytes_left,
   input  logic               hold_pending,
   output logic [NUM_IRQ-1:0] irq,
   output logic               xfer_release
);
   import sst_pkg::*;

   localparam int NARROW_W = 8;
   localparam int WCNT_W   = CNT_W + 1;
   localparam int ID_TAG_W = ADDR_W - 5;

   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must cover the 4 KiB register window");
   end
   if (EVT_W + LIVE_W > DATA_W) begin : g_bad_status
      $error("status fields do not fit the data width");
   end
   if (NUM_IRQ < 1 || NUM_IRQ > 3) begin : g_bad_irq
      $error("NUM_IRQ must be 1 to 3 so masks stay below the count register");
   end
   if (DATA_W < WCNT_W || DATA_W < NARROW_W) begin : g_bad_data
      $error("data width too narrow");
   end

   logic [EVT_W-1:0]              sticky_q;
   logic [EVT_W-1:0]              clr_bits;
   logic [NARROW_W-1:0]           power_q, clock_q, dctrl_q;
   logic [NUM_IRQ-1:0][DATA_W-1:0] mask_q;
   logic [DATA_W-1:0]             status_w;
   logic [WCNT_W-1:0]             words_left;
   logic [DATA_W-1:0]             rd_val;
   logic                          hit_clr, hit_stat, hit_fcnt, hit_id;

   assign hit_clr  = reg_addr == ADDR_W'(OFF_CLEAR);
   assign hit_stat = reg_addr == ADDR_W'(OFF_STATUS);
   assign hit_fcnt = reg_addr == ADDR_W'(OFF_FCOUNT);
   assign hit_id   = reg_addr[ADDR_W-1:5] == ID_TAG_W'(ID_BASE >> 5);

   assign clr_bits = (reg_wr && hit_clr) ? reg_wdata[EVT_W-1:0] : '0;

   sst_sticky #(.EVT_W(EVT_W)) sticky_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (evt_set),
      .clr_i    (clr_bits),
      .sticky_q (sticky_q)
   );

   sst_ctlregs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ), .NARROW_W(NARROW_W)
   ) ctl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .power_q (power_q),
      .clock_q (clock_q),
      .dctrl_q (dctrl_q),
      .mask_q  (mask_q)
   );

   always_comb begin
      status_w = '0;
      status_w[EVT_W-1:0]       = sticky_q;
      status_w[EVT_W +: LIVE_W] = fifo_live;
   end

   sst_irq #(.DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ)) irq_i (
      .status_w (status_w),
      .mask_q   (mask_q),
      .irq      (irq)
   );

   // Round up to whole words; one extra bit avoids overflow at the top count
   assign words_left = (WCNT_W'(bytes_left) + WCNT_W'(3)) >> 2;

   always_comb begin
      rd_val = '0;
      if (hit_id) begin
         rd_val[NARROW_W-1:0] = id_byte(reg_addr[4:2]);
      end else if (hit_stat) begin
         rd_val = status_w;
      end else if (hit_fcnt) begin
         rd_val = DATA_W'(words_left);
      end else if (reg_addr == ADDR_W'(OFF_POWER)) begin
         rd_val = DATA_W'(power_q);
      end else if (reg_addr == ADDR_W'(OFF_CLOCK)) begin
         rd_val = DATA_W'(clock_q);
      end else if (reg_addr == ADDR_W'(OFF_DCTRL)) begin
         rd_val = DATA_W'(dctrl_q);
      end else begin
         for (int i = 0; i < NUM_IRQ; i++) begin
            if (reg_addr == ADDR_W'(OFF_MASK0 + 4 * i)) rd_val = mask_q[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata    <= '0;
         xfer_release <= 1'b0;
      end else begin
         reg_rdata    <= reg_rd ? rd_val : '0;
         xfer_release <= reg_rd && (hit_stat || hit_fcnt) && hold_pending;
      end
   end
endmodule

// File: rtl/sst_chk.sv
module sst_chk #(
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 32,
   parameter int EVT_W   = 11,
   parameter int NUM_IRQ = 2
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            reg_wr,
   input logic                            reg_rd,
   input logic [ADDR_W-1:0]               reg_addr,
   input logic [DATA_W-1:0]               reg_wdata,
   input logic [DATA_W-1:0]               reg_rdata,
   input logic [EVT_W-1:0]                evt_set,
   input logic [EVT_W-1:0]                sticky_q,
   input logic [NUM_IRQ-1:0][DATA_W-1:0]  mask_q,
   input logic [NUM_IRQ-1:0]              irq,
   input logic                            xfer_release
);
   localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'('h038);

   // R1
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == CLR_A) |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

   // R3
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_set) |=> ((sticky_q & $past(evt_set)) == $past(evt_set)));

   // R2
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == CLR_A) |=>
         ((sticky_q & $past(reg_wdata[EVT_W-1:0]) & ~$past(evt_set)) == '0));

   // R9
   release_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_release |-> $past(reg_rd));

   // R10
   clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == CLR_A) |=> (reg_rdata == '0));

   // R11
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> (reg_rdata == '0));

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq_chk
      // R5
      irq_follows_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((sticky_q & mask_q[i][EVT_W-1:0]) != '0) |-> irq[i]);
   end
endmodule

bind status_irq_unit sst_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EVT_W(EVT_W), .NUM_IRQ(NUM_IRQ)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_wr       (reg_wr),
   .reg_rd       (reg_rd),
   .reg_addr     (reg_addr),
   .reg_wdata    (reg_wdata),
   .reg_rdata    (reg_rdata),
   .evt_set      (evt_set),
   .sticky_q     (sticky_q),
   .mask_q       (mask_q),
   .irq          (irq),
   .xfer_release (xfer_release)
);

// File: tb/status_irq_unit_tb_top.sv
`timescale 1ns/1ps
module status_irq_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [10:0] evt_set = '0;
   logic [10:0] fifo_live = '0;
   logic [15:0] bytes_left = '0;
   logic        hold_pending = 1'b0;
   logic [1:0]  irq;
   logic        xfer_release;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   status_irq_unit dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .evt_set(evt_set), .fifo_live(fifo_live), .bytes_left(bytes_left),
      .hold_pending(hold_pending), .irq(irq), .xfer_release(xfer_release)
   );

   // Reference model state
   int unsigned m_sticky, m_pow, m_clk, m_dct;
   int unsigned m_mask [2];
   logic [31:0] exp_rd;
   bit          exp_rel;
   string       rd_tag = "R11";

   function automatic int unsigned m_status();
      return (int'(fifo_live) << 11) | m_sticky;
   endfunction

   function automatic logic [31:0] m_read(input logic [11:0] a);
      logic [7:0] ids [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      if (a >= 12'hFE0) return {24'h0, ids[a[4:2]]};
      case (a)
         12'h000: return m_pow;
         12'h004: return m_clk;
         12'h02C: return m_dct;
         12'h034: return m_status();
         12'h03C: return m_mask[0];
         12'h040: return m_mask[1];
         12'h048: return (int'(bytes_left) + 3) / 4;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(input logic [11:0] a);
      if (a >= 12'hFE0) return "R7";
      case (a)
         12'h000, 12'h004, 12'h02C: return "R8";
         12'h034: return "R4";
         12'h03C, 12'h040: return "R5";
         12'h048: return "R6";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input bit wr, input bit rd, input logic [11:0] a,
                      input logic [31:0] d, input logic [10:0] ev);
      logic [1:0] e_irq;
      reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d; evt_set = ev;
      @(posedge clk);
      if (!rst_n) begin
         m_sticky = 0; m_pow = 0; m_clk = 0; m_dct = 0;
         m_mask[0] = 0; m_mask[1] = 0;
         exp_rd = 0; exp_rel = 0; rd_tag = "R11";
      end else begin
         exp_rd  = rd ? m_read(a) : 32'h0;
         rd_tag  = rd ? tag_of(a) : "R11";
         exp_rel = rd && (a == 12'h034 || a == 12'h048) && hold_pending;
         if (wr) begin
            case (a)
               12'h000: m_pow = d & 32'hFF;
               12'h004: m_clk = d & 32'hFF;
               12'h02C: m_dct = d & 32'hFF;
               12'h03C: m_mask[0] = d;
               12'h040: m_mask[1] = d;
               12'h038: m_sticky = m_sticky & ~(d & 32'h7FF);
               default: ;
            endcase
         end
         m_sticky = m_sticky | ev;   // R3 set after clear
      end
      @(negedge clk);
      reg_wr = 0; reg_rd = 0; evt_set = '0;
      e_irq[0] = (m_status() & m_mask[0]) != 0;
      e_irq[1] = (m_status() & m_mask[1]) != 0;
      check(rd_tag, reg_rdata, exp_rd);
      check("R5", {30'h0, irq}, {30'h0, e_irq});
      check("R9", {31'h0, xfer_release}, {31'h0, exp_rel});
   endtask

   task automatic rd(input logic [11:0] a);
      cyc(0, 1, a, 32'h0, '0);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      cyc(1, 0, a, d, '0);
   endtask

   initial begin
      // R11 reset state
      repeat (3) cyc(0, 0, 12'h0, 32'h0, '0);
      rst_n = 1'b1;
      rd(12'h034);
      // R8 narrow control registers
      wr(12'h000, 32'hFFFF_F1A5); rd(12'h000);
      wr(12'h004, 32'h1234_5678); rd(12'h004);
      wr(12'h02C, 32'hDEAD_BE3C); rd(12'h02C);
      // R5 masks read back full width
      wr(12'h03C, 32'h0000_0009); rd(12'h03C);
      wr(12'h040, 32'h0020_0000); rd(12'h040);
      // R1 strobe sets and holds, drives irq0
      cyc(0, 0, 12'h0, 32'h0, 11'h001);
      repeat (2) rd(12'h034);
      // R5 live flag bit 21 drives irq1 without storage
      fifo_live = 11'h400; rd(12'h034);
      fifo_live = 11'h001; rd(12'h034);
      // R2 clear all-ones; live bits survive
      cyc(0, 0, 12'h0, 32'h0, 11'h7FF);
      wr(12'h038, 32'hFFFF_F00F); rd(12'h034);
      wr(12'h038, 32'hFFFF_FFFF); rd(12'h034);
      // R3 same-edge set and clear
      cyc(1, 0, 12'h038, 32'h0000_0008, 11'h008); rd(12'h034);
      wr(12'h038, 32'h0000_0008); rd(12'h034);
      // R6 word count rounding
      bytes_left = 16'd0;     rd(12'h048);
      bytes_left = 16'd1;     rd(12'h048);
      bytes_left = 16'd4;     rd(12'h048);
      bytes_left = 16'd5;     rd(12'h048);
      bytes_left = 16'hFFFF;  rd(12'h048);
      // R7 identification bytes
      for (int i = 0; i < 8; i++) rd(12'hFE0 + 12'(4 * i));
      // R9 release on status and count reads only while held
      hold_pending = 1'b1;
      rd(12'h034); rd(12'h048); rd(12'h000); rd(12'h03C);
      hold_pending = 1'b0;
      rd(12'h034);
      // R10 unmapped and write-only offsets
      rd(12'h038); rd(12'h100); rd(12'h044);
      wr(12'h100, 32'hFFFF_FFFF); wr(12'h034, 32'hFFFF_FFFF); wr(12'h048, 32'h1);
      rd(12'h000); rd(12'h034); rd(12'h03C); rd(12'h040);
      // R11 data returns to zero when idle
      cyc(0, 0, 12'h0, 32'h0, '0);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule